// File: doc/BRIEF.md
# Digital PWM Channel with Sync, Inverted Duty and Resonant Pulse Modes

This block is one channel of a digital pulse-width modulator. A free-running counter sweeps each switching period. Two outputs, A and B, are built from an on-time. The on-time is normally derived from a duty word delivered by an upstream compensator.

The channel can emit a sync pulse for neighbouring channels. It can also act as a slave and restart its own counter on a pulse chosen from a bundle of peer sync lines. Two control bits change how the on-time is formed:

- An inversion bit makes the on-time equal to the period minus the duty.
- A resonant mode gives each output a half-period pulse less a dead time, or a fixed width taken from a threshold word.

When a fault is present, or when the channel is not enabled, each output is forced to its own programmable safe level. While reset is held, both outputs are low.

Period, duty, phase and threshold words are captured into shadow registers only when the counter wraps or restarts. A word changed in mid-period therefore takes effect at the next period boundary.

Top module: `pwm_chan`

## Requirements
- R1: The counter runs from 0 to period-1 and then returns to 0, so the output pattern repeats every `period` cycles. A period of 0 or 1 keeps the count at 0.
- R2: `sync_out` is high for one cycle when the count equals the shadow phase word (`sync_from_duty`=0) or the shadow duty word (`sync_from_duty`=1). It never fires if that value is at or above the period.
- R3: Output A is high while the count is below the on-time.
- R4: Output B is high while the count is at least half the period (rounded down) and below half the period plus the on-time, with that end limited to the period.
- R5: Period, duty, phase and threshold changes take effect only from the cycle in which the count next returns to 0.
- R6: With `duty_invert`=1 and resonant mode off, the on-time equals the period minus the duty. A duty of 0 gives a pulse for the whole period.
- R7: In any cycle in which `fault`=1 or `en`=0, `pwm_a` equals `safe_a` and `pwm_b` equals `safe_b`, in that same cycle. The counter keeps running.
- R8: While `rst_n`=0, and in the cycle just after it, `pwm_a`, `pwm_b` and `sync_out` are 0, whatever the safe levels are.
- R9: A duty word above the period is treated as equal to the period. The on-time never exceeds the period.
- R10: With `slave_en`=1, a high level on `peer_sync[peer_sel]` at a clock edge makes the count 0 after that edge. Other peer lines, and any line while `slave_en`=0, have no effect.
- R11: With `res_mode`=1 and `res_fixed`=0, the on-time is half the period minus the dead time DEAD, floored at 0. Inversion is ignored in this mode.
- R12: With `res_mode`=1 and `res_fixed`=1, the on-time is the threshold word, limited to half the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable; 0 forces the safe levels |
| fault | input | 1 | Fault present; 1 forces the safe levels |
| period | input | CW | Period in clock cycles |
| duty | input | CW | Duty word from the compensator |
| phase | input | CW | Count at which the sync pulse fires in phase mode |
| res_thresh | input | CW | Fixed pulse width for resonant fixed mode |
| sync_from_duty | input | 1 | 0: sync at phase word, 1: sync at duty word |
| slave_en | input | 1 | Accept a counter restart from a peer |
| peer_sync | input | NCH | Sync pulses from other channels |
| peer_sel | input | SELW | Index of the peer sync line followed |
| duty_invert | input | 1 | On-time = period - duty |
| res_mode | input | 1 | Resonant pulse mode |
| res_fixed | input | 1 | Resonant width taken from `res_thresh` |
| safe_a | input | 1 | Level of A under fault or disable |
| safe_b | input | 1 | Level of B under fault or disable |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| sync_out | output | 1 | Sync pulse for other channels |

## Verification
The channel is driven with several duty words at a fixed period:

- a small duty, to place the A and B windows;
- a mid-period duty change, to show that it is deferred to the wrap;
- a zero and a full-scale duty with inversion, which separates the direct on-time from the inverted one;
- a duty above the period, which shows the clamp.

The sync source is switched between phase and duty, and the phase is also set beyond the period, so the two compare targets can be told apart. Resonant runs use an even period with a free width and with thresholds below and above half the period. Slave runs pulse the selected and an unselected peer line, which shows that only the chosen one restarts the count.

// File: rtl/pwm_chan_pkg.sv
// Package: shared definitions for the PWM channel.
// Assumes: widths are set by the users of these helpers.
package pwm_chan_pkg;

    // Number of modulated outputs per channel (A and B).
    localparam int NUM_OUT = 2;

    // Output indices, fixed by the window each output uses.
    localparam int OUT_A = 0;
    localparam int OUT_B = 1;

endpackage

// File: rtl/pwm_counter.sv
// Module: period counter with shadow capture and slave restart.
// Counts 0..period-1. On a wrap, or on a restart taken from a selected peer sync
// line, the count returns to 0 and the period/duty/phase/threshold shadows reload.
// Assumes: peer_sel < NCH; a shadow period of 0 or 1 wraps on every cycle.
module pwm_counter #(
    parameter int CW   = 10,
    parameter int NCH  = 4,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   period,
    input  logic [CW-1:0]   duty,
    input  logic [CW-1:0]   phase,
    input  logic [CW-1:0]   thresh,
    input  logic            slave_en,
    input  logic [NCH-1:0]  peer_sync,
    input  logic [SELW-1:0] peer_sel,
    output logic [CW-1:0]   cnt,
    output logic [CW-1:0]   per_s,
    output logic [CW-1:0]   duty_s,
    output logic [CW-1:0]   phase_s,
    output logic [CW-1:0]   thr_s
);
    logic [CW:0] cnt_inc;
    logic        wrap;
    logic        restart;
    logic        load;

    // Detect end of period and a peer restart request.
    always_comb begin
        cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
        wrap    = (cnt_inc >= {1'b0, per_s});
        restart = slave_en & peer_sync[peer_sel];
        load    = wrap | restart;
    end

    // Advance or clear the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[CW-1:0];
        end
    end

    // Capture the working words at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_s   <= '0;
            duty_s  <= '0;
            phase_s <= '0;
            thr_s   <= '0;
        end else if (load) begin
            per_s   <= period;
            duty_s  <= duty;
            phase_s <= phase;
            thr_s   <= thresh;
        end
    end

endmodule

// File: rtl/pwm_ontime.sv
// Module: on-time arithmetic.
// Picks the on-time from the clamped duty, its inverse against the period,
// or one of the two resonant widths. Also provides half the period.
// Assumes: inputs come from the shadow registers, so the result is steady within a period.
module pwm_ontime #(
    parameter int CW   = 10,
    parameter int DEAD = 2
) (
    input  logic [CW-1:0] per_s,
    input  logic [CW-1:0] duty_s,
    input  logic [CW-1:0] thr_s,
    input  logic          duty_invert,
    input  logic          res_mode,
    input  logic          res_fixed,
    output logic [CW-1:0] half,
    output logic [CW-1:0] on_time
);
    localparam logic [CW-1:0] DEAD_W = CW'(DEAD);

    logic [CW-1:0] duty_c;
    logic [CW-1:0] inv_on;
    logic [CW-1:0] res_free;
    logic [CW-1:0] res_fix;

    // Clamp the duty, then form the candidate widths.
    always_comb begin
        duty_c   = (duty_s > per_s) ? per_s : duty_s;
        half     = per_s >> 1;
        inv_on   = per_s - duty_c;
        res_free = (half > DEAD_W) ? (half - DEAD_W) : '0;
        res_fix  = (thr_s > half) ? half : thr_s;
    end

    // Select the on-time for the active mode.
    always_comb begin
        if (res_mode) begin
            on_time = res_fixed ? res_fix : res_free;
        end else begin
            on_time = duty_invert ? inv_on : duty_c;
        end
    end

endmodule

// File: rtl/pwm_outgen.sv
// Module: output window compare and fault override.
// Each output is high over [start, min(start+on_time, period)). A starts at 0 and
// B at half the period. Fault or disable forces the safe level in the same cycle.
// The outputs stay low until the first clock after reset.
// Assumes: cnt < per_s whenever per_s is non-zero.
module pwm_outgen
    import pwm_chan_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      cnt,
    input  logic [CW-1:0]      per_s,
    input  logic [CW-1:0]      half,
    input  logic [CW-1:0]      on_time,
    input  logic               en,
    input  logic               fault,
    input  logic [NUM_OUT-1:0] safe_lvl,
    output logic               armed,
    output logic [NUM_OUT-1:0] pwm
);
    // Hold the outputs low from reset until the first active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        logic [CW:0] start_w;
        logic [CW:0] stop_w;
        logic [CW:0] lim_w;
        logic        raw;

        if (g == OUT_A) begin : g_start_a
            assign start_w = '0;
        end else begin : g_start_b
            assign start_w = {1'b0, half};
        end

        // Window compare, then the override.
        always_comb begin
            stop_w = start_w + {1'b0, on_time};
            lim_w  = (stop_w > {1'b0, per_s}) ? {1'b0, per_s} : stop_w;
            raw    = ({1'b0, cnt} >= start_w) && ({1'b0, cnt} < lim_w);
            if (!armed) begin
                pwm[g] = 1'b0;
            end else if (en && !fault) begin
                pwm[g] = raw;
            end else begin
                pwm[g] = safe_lvl[g];
            end
        end
    end

endmodule

// File: rtl/pwm_chan.sv
// Module: top of the PWM channel.
// Ties together the counter, the on-time logic and the output stage, and makes the
// sync pulse from the phase or duty shadow word.
// Assumes: control bits are static or change in a way the caller tolerates; only the data words are shadowed.
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CW   = 10,
    parameter int NCH  = 4,
    parameter int DEAD = 2,
    parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            fault,
    input  logic [CW-1:0]   period,
    input  logic [CW-1:0]   duty,
    input  logic [CW-1:0]   phase,
    input  logic [CW-1:0]   res_thresh,
    input  logic            sync_from_duty,
    input  logic            slave_en,
    input  logic [NCH-1:0]  peer_sync,
    input  logic [SELW-1:0] peer_sel,
    input  logic            duty_invert,
    input  logic            res_mode,
    input  logic            res_fixed,
    input  logic            safe_a,
    input  logic            safe_b,
    output logic            pwm_a,
    output logic            pwm_b,
    output logic            sync_out
);
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      per_s;
    logic [CW-1:0]      duty_s;
    logic [CW-1:0]      phase_s;
    logic [CW-1:0]      thr_s;
    logic [CW-1:0]      half;
    logic [CW-1:0]      on_time;
    logic               armed;
    logic [NUM_OUT-1:0] pwm;
    logic [CW-1:0]      sync_tgt;

    pwm_counter #(.CW(CW), .NCH(NCH), .SELW(SELW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .period    (period),
        .duty      (duty),
        .phase     (phase),
        .thresh    (res_thresh),
        .slave_en  (slave_en),
        .peer_sync (peer_sync),
        .peer_sel  (peer_sel),
        .cnt       (cnt),
        .per_s     (per_s),
        .duty_s    (duty_s),
        .phase_s   (phase_s),
        .thr_s     (thr_s)
    );

    pwm_ontime #(.CW(CW), .DEAD(DEAD)) u_on (
        .per_s       (per_s),
        .duty_s      (duty_s),
        .thr_s       (thr_s),
        .duty_invert (duty_invert),
        .res_mode    (res_mode),
        .res_fixed   (res_fixed),
        .half        (half),
        .on_time     (on_time)
    );

    pwm_outgen #(.CW(CW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .per_s    (per_s),
        .half     (half),
        .on_time  (on_time),
        .en       (en),
        .fault    (fault),
        .safe_lvl ({safe_b, safe_a}),
        .armed    (armed),
        .pwm      (pwm)
    );

    // Sync pulse when the count meets the selected target.
    always_comb begin
        sync_tgt = sync_from_duty ? duty_s : phase_s;
        sync_out = armed && (cnt == sync_tgt);
        pwm_a    = pwm[OUT_A];
        pwm_b    = pwm[OUT_B];
    end

endmodule

// File: rtl/pwm_chan_chk.sv
// Module: property checker for pwm_chan, attached to it by bind.
// Watches the ports and the counter state the design drives.
module pwm_chan_chk #(
    parameter int CW   = 10,
    parameter int NCH  = 4,
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            fault,
    input logic            safe_a,
    input logic            safe_b,
    input logic            pwm_a,
    input logic            pwm_b,
    input logic            slave_en,
    input logic [NCH-1:0]  peer_sync,
    input logic [SELW-1:0] peer_sel,
    input logic [CW-1:0]   cnt,
    input logic [CW-1:0]   per_s,
    input logic [CW-1:0]   on_time
);
    // R8: reset keeps both outputs low.
    assert_reset_low_R8: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));

    // R7: fault forces the safe levels in the same cycle.
    assert_fault_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(rst_n)) |-> (pwm_a == safe_a && pwm_b == safe_b));

    // R1: count stays below a non-zero period.
    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (per_s != '0) |-> (cnt < per_s));

    // R10: the selected peer pulse restarts the count.
    assert_slave_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && peer_sync[peer_sel]) |=> (cnt == '0));

    // R9: on-time never exceeds the period.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        on_time <= per_s);

    // R3: zero on-time means A stays low when running.
    assert_a_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_time == '0 && en && !fault && $past(rst_n)) |-> !pwm_a);

endmodule

bind pwm_chan pwm_chan_chk #(.CW(CW), .NCH(NCH), .SELW(SELW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .fault     (fault),
    .safe_a    (safe_a),
    .safe_b    (safe_b),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .slave_en  (slave_en),
    .peer_sync (peer_sync),
    .peer_sel  (peer_sel),
    .cnt       (cnt),
    .per_s     (per_s),
    .on_time   (on_time)
);

// File: tb/pwm_chan_tb.sv
`timescale 1ns/1ps
module pwm_chan_tb;
    localparam int CW   = 10;
    localparam int NCH  = 4;
    localparam int DEAD = 2;
    localparam int SELW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0, fault = 1'b0;
    logic [CW-1:0]   period = '0, duty = '0, phase = '0, res_thresh = '0;
    logic            sync_from_duty = 1'b0, slave_en = 1'b0;
    logic [NCH-1:0]  peer_sync = '0;
    logic [SELW-1:0] peer_sel = '0;
    logic            duty_invert = 1'b0, res_mode = 1'b0, res_fixed = 1'b0;
    logic            safe_a = 1'b0, safe_b = 1'b0;
    logic            pwm_a, pwm_b, sync_out;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_chan #(.CW(CW), .NCH(NCH), .DEAD(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .fault(fault),
        .period(period), .duty(duty), .phase(phase), .res_thresh(res_thresh),
        .sync_from_duty(sync_from_duty), .slave_en(slave_en),
        .peer_sync(peer_sync), .peer_sel(peer_sel),
        .duty_invert(duty_invert), .res_mode(res_mode), .res_fixed(res_fixed),
        .safe_a(safe_a), .safe_b(safe_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_out(sync_out)
    );

    // Reference state built from the requirements.
    int m_cnt = 0, m_per = 0, m_duty = 0, m_phase = 0, m_thr = 0;
    bit m_armed = 0;

    typedef struct {
        logic  a;
        logic  b;
        logic  s;
        string tag;
    } exp_t;
    exp_t q[$];

    function automatic int min2(int x, int y);
        return (x < y) ? x : y;
    endfunction

    // Driver side: expected outputs for the current cycle.
    task automatic push_exp(input string tag);
        exp_t e;
        int d, half, on, lim;
        logic ra, rb;
        d    = min2(m_duty, m_per);
        half = m_per / 2;
        if (res_mode) on = res_fixed ? min2(m_thr, half) : ((half > DEAD) ? half - DEAD : 0);
        else          on = duty_invert ? (m_per - d) : d;
        lim = min2(half + on, m_per);
        ra  = (m_cnt < on);
        rb  = (m_cnt >= half) && (m_cnt < lim);
        if (!m_armed) begin
            e.a = 1'b0; e.b = 1'b0;
        end else if (en && !fault) begin
            e.a = ra; e.b = rb;
        end else begin
            e.a = safe_a; e.b = safe_b;
        end
        e.s   = m_armed && (m_cnt == (sync_from_duty ? m_duty : m_phase));
        e.tag = tag;
        q.push_back(e);
    endtask

    // Advance the reference across one clock edge.
    task automatic model_edge();
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_phase = 0; m_thr = 0; m_armed = 0;
        end else begin
            if ((slave_en && peer_sync[peer_sel]) || (m_cnt + 1 >= m_per)) begin
                m_cnt = 0;
                m_per = int'(period); m_duty = int'(duty);
                m_phase = int'(phase); m_thr = int'(res_thresh);
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_armed = 1;
        end
    endtask

    task automatic cyc(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            push_exp(tag);
            @(posedge clk);
            #1;
            model_edge();
        end
    endtask

    // Monitor: compare outputs away from the active edge.
    always @(negedge clk) begin : mon
        exp_t e;
        while (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (pwm_a !== e.a || pwm_b !== e.b || sync_out !== e.s) begin
                bad++;
                $display("FAIL %s t=%0t a/b/sync actual=%b%b%b expected=%b%b%b",
                         e.tag, $time, pwm_a, pwm_b, sync_out, e.a, e.b, e.s);
            end
        end
    end

    initial begin
        @(posedge clk); #1; model_edge();
        // R8: reset with safe levels high
        safe_a = 1; safe_b = 1; en = 1; period = 10; duty = 3; phase = 12;
        cyc("R8", 3);
        rst_n = 1;
        cyc("R8", 1);
        // R7: disabled shows safe levels
        en = 0; safe_a = 1; safe_b = 0;
        cyc("R7", 12);
        // R1 R3 R4: basic windows
        en = 1;
        cyc("R1", 12);
        cyc("R3", 10);
        cyc("R4", 10);
        // R5: mid-period change deferred to wrap
        cyc("R5", 4);
        duty = 6; period = 9;
        cyc("R5", 22);
        // R6: inversion
        period = 10; duty = 2; duty_invert = 1;
        cyc("R6", 22);
        duty = 0;
        cyc("R6", 22);
        // R9: duty above period
        duty = 15; duty_invert = 0;
        cyc("R9", 22);
        duty_invert = 1;
        cyc("R9", 22);
        duty_invert = 0;
        // R2: sync sources
        duty = 7; phase = 4; sync_from_duty = 0;
        cyc("R2", 22);
        sync_from_duty = 1;
        cyc("R2", 22);
        sync_from_duty = 0; phase = 12;
        cyc("R2", 22);
        // R7: fault pulses
        duty = 4; safe_b = 1; safe_a = 0;
        cyc("R7", 3);
        fault = 1; cyc("R7", 2);
        fault = 0; cyc("R7", 5);
        fault = 1; cyc("R7", 12);
        fault = 0; cyc("R7", 4);
        // R10: slave restart on selected line only
        slave_en = 1; peer_sel = 2;
        cyc("R10", 4);
        peer_sync = 4'b0100; cyc("R10", 1);
        peer_sync = 4'b0000; cyc("R10", 6);
        peer_sync = 4'b0010; cyc("R10", 2);
        peer_sync = 4'b0000; cyc("R10", 4);
        slave_en = 0; peer_sync = 4'b0100; cyc("R10", 3);
        peer_sync = 4'b0000; cyc("R10", 12);
        // R11 R12: resonant
        period = 20; res_mode = 1; res_fixed = 0; duty_invert = 1;
        cyc("R11", 45);
        res_fixed = 1; res_thresh = 5;
        cyc("R12", 45);
        res_thresh = 30;
        cyc("R12", 45);
        @(negedge clk);
        #1;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule